// File: doc/BRIEF.md
# Dual Timer/Counter with Split Mode

This block holds two 16-bit timer/counters, here called Timer 0 and Timer 1, built in the manner of a small microcontroller. Each one has a two-bit mode field. The modes are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself, and a split mode. By default both timers count machine cycles. The machine-cycle enable `mc_en` is high for one system clock in every machine cycle, for example once per twelve oscillator periods. Timer 0 can instead count falling edges on an external pin. Timer 0 can also be gated by the level of an external gate pin.

In split mode Timer 0 becomes two separate 8-bit counters:

- The low byte keeps Timer 0's own run, gate and count-source controls, and sets flag 0 when it wraps.
- The high byte always counts machine cycles. It is enabled only by Timer 1's run bit, and it sets flag 1 when it wraps.

A Timer 1 that is placed in split mode holds its count. While Timer 0 is split, Timer 1 runs in any other mode whatever its run bit says. Its overflow tick `t1_tick` can still serve as a baud-rate source, but in that case it does not set flag 1.

Software writes the 8-bit control byte and the four counter bytes through simple write ports, and clears each flag with its own strobe. The counters can be read back at all times on `cnt0` and `cnt1`.

Top module: `dual_timer`

## Requirements
- R1: After reset, both counters, both flags, `t1_tick` and the control byte are zero.
- R2: The control byte is `{mode1[1:0], mode0[1:0], src0, gate0, run1, run0}` (bit 7 down to bit 0). The mode codes are 0 = 13-bit, 1 = 16-bit, 2 = reload and 3 = split. In mode 1 a running timer adds one on each clock where `mc_en` is high and holds while `mc_en` is low or its run bit is clear. It wraps from 16'hFFFF to 0 and sets its flag.
- R3: In mode 0 the low byte's bits [4:0] act as a prescaler and bits [7:5] keep their value. A carry out of the prescaler increments the high byte. The overflow occurs when the high byte is 8'hFF and the prescaler is 5'h1F.
- R4: In mode 2 the low byte counts. When it is 8'hFF, the next count loads it from the high byte and sets the flag. The high byte does not change.
- R5: In Timer 0 split mode the low byte counts only when run0 && (!gate0 || gate_pin). It sets flag 0 when it wraps 8'hFF to 0 and never changes the high byte.
- R6: In Timer 0 split mode the high byte counts `mc_en` cycles whenever run1 is set, independent of run0, gate0 and src0. It sets flag 1 when it wraps.
- R7: A Timer 1 in mode 3 holds its count and produces no `t1_tick`.
- R8: While Timer 0 is split, a Timer 1 in mode 0, 1 or 2 counts even with run1 clear, and its wrap does not set flag 1. Switching Timer 1 into mode 3 stops it, and switching it back resumes it.
- R9: With src0 = 1, the Timer 0 count source is the external count pin, which is sampled once per machine cycle. Each 1-then-0 pair of consecutive samples adds exactly one count.
- R10: `clr0` and `clr1` clear their flags. A flag set in the same cycle as its clear strobe stays set.
- R11: `wr_sel` is one-hot: bit 0 selects the Timer 0 low byte, bit 1 the Timer 0 high byte, bit 2 the Timer 1 low byte and bit 3 the Timer 1 high byte. A written byte takes `wr_data` in that cycle, even if a count would have changed it.
- R12: Outside Timer 0 split mode, a Timer 1 wrap sets flag 1. In every case where Timer 1 is not in mode 3, the wrap raises `t1_tick` for exactly one clock in the cycle after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_en | input | 1 | Machine-cycle enable, one clock per machine cycle |
| cnt_pin | input | 1 | External count pin for Timer 0 |
| gate_pin | input | 1 | External gate level for Timer 0 |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte value |
| wr_sel | input | 4 | One-hot counter byte write select |
| wr_data | input | 8 | Counter byte write value |
| clr0 | input | 1 | Clear strobe for flag 0 |
| clr1 | input | 1 | Clear strobe for flag 1 |
| flag0 | output | 1 | Timer 0 (or split low byte) overflow flag |
| flag1 | output | 1 | Timer 1 (or split high byte) overflow flag |
| t1_tick | output | 1 | One-clock pulse on each Timer 1 wrap |
| cnt0 | output | 16 | Timer 0 count, high byte first |
| cnt1 | output | 16 | Timer 1 count, high byte first |

## Verification
The hardest case to reach is the hand-over of Timer 1's resources while Timer 0 is split. It requires Timer 1 to wrap and tick without touching flag 1, and then to freeze and restart solely through its own mode field. The bench reaches it as follows:

1. Preload Timer 1 two counts short of a wrap.
2. Split Timer 0 with run1 cleared, so that the high byte stands still and cannot set flag 1 itself.
3. Toggle Timer 1's mode field between 3 and 1, and check at each step that the count is frozen in mode 3 and advances again in mode 1.

The same-cycle clear-versus-set case is reached by a preload of all ones, so that the wrap falls on the first running clock, with the clear strobe placed on exactly that clock.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
    localparam int BYTE_W = 8;
    localparam int PRE_W  = 5;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int NTMR   = 2;

    typedef enum logic [1:0] {
        MD_13B    = 2'd0,
        MD_16B    = 2'd1,
        MD_RELOAD = 2'd2,
        MD_SPLIT  = 2'd3
    } mode_e;

    typedef struct packed {
        logic [1:0] mode1;
        logic [1:0] mode0;
        logic       src0;
        logic       gate0;
        logic       run1;
        logic       run0;
    } ctl_t;

    typedef struct packed {
        ctl_t             ctl;
        logic [CNT_W-1:0] c0;
        logic [CNT_W-1:0] c1;
        logic             f0;
        logic             f1;
        logic             tick;
    } st_t;
endpackage

// File: rtl/dtmr_pin_edge.sv
module dtmr_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_en,
    input  logic pin,
    output logic fall
);
    logic samp_d, samp_q, old_d, old_q;

    always_comb begin
        samp_d = samp_q;
        old_d  = old_q;
        if (mc_en) begin
            samp_d = pin;
            old_d  = samp_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            old_q  <= 1'b0;
        end else begin
            samp_q <= samp_d;
            old_q  <= old_d;
        end
    end

    // one count per 1 -> 0 pair of samples, consumed on the next machine cycle
    assign fall = mc_en & old_q & ~samp_q;
endmodule

// File: rtl/dtmr_step.sv
module dtmr_step
    import dtmr_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic             inc,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf
);
    logic [BYTE_W-1:0] lo, hi;
    logic [PRE_W-1:0]  pre;

    always_comb begin
        lo    = cnt_i[BYTE_W-1:0];
        hi    = cnt_i[CNT_W-1:BYTE_W];
        pre   = lo[PRE_W-1:0];
        ovf   = 1'b0;
        cnt_o = cnt_i;
        if (inc) begin
            case (mode_e'(mode))
                MD_13B: begin
                    if (&pre) begin
                        ovf = &hi;
                        lo[PRE_W-1:0] = '0;
                        hi = hi + BYTE_W'(1);
                    end else begin
                        lo[PRE_W-1:0] = pre + PRE_W'(1);
                    end
                    cnt_o = {hi, lo};
                end
                MD_16B: begin
                    ovf   = &cnt_i;
                    cnt_o = cnt_i + CNT_W'(1);
                end
                MD_RELOAD: begin
                    if (&lo) begin
                        ovf = 1'b1;
                        lo  = hi;
                    end else begin
                        lo = lo + BYTE_W'(1);
                    end
                    cnt_o = {hi, lo};
                end
                default: cnt_o = cnt_i;
            endcase
        end
    end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
    import dtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_en,
    input  logic              cnt_pin,
    input  logic              gate_pin,
    input  logic              ctl_we,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic [3:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              clr0,
    input  logic              clr1,
    output logic              flag0,
    output logic              flag1,
    output logic              t1_tick,
    output logic [CNT_W-1:0]  cnt0,
    output logic [CNT_W-1:0]  cnt1
);
    st_t  q, d;
    ctl_t ctl_w;
    logic pin_fall;
    logic t0_split, t1_split, low_open, t0_inc;
    logic lo_inc, hi_inc, lo_ovf, hi_ovf;
    logic [NTMR-1:0][1:0]       md;
    logic [NTMR-1:0]            inc;
    logic [NTMR-1:0][CNT_W-1:0] cin, cout;
    logic [NTMR-1:0]            ovf;

    assign ctl_w = q.ctl;

    dtmr_pin_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .mc_en(mc_en),
        .pin  (cnt_pin),
        .fall (pin_fall)
    );

    always_comb begin
        t0_split = (ctl_w.mode0 == MD_SPLIT);
        t1_split = (ctl_w.mode1 == MD_SPLIT);
        low_open = ctl_w.run0 & (~ctl_w.gate0 | gate_pin);
        t0_inc   = low_open & (ctl_w.src0 ? pin_fall : mc_en);
        md[0]    = ctl_w.mode0;
        md[1]    = ctl_w.mode1;
        inc[0]   = t0_inc & ~t0_split;
        inc[1]   = mc_en & ~t1_split & (t0_split | ctl_w.run1);
        cin[0]   = q.c0;
        cin[1]   = q.c1;
        lo_inc   = t0_split & t0_inc;
        hi_inc   = t0_split & ctl_w.run1 & mc_en;
        lo_ovf   = lo_inc & (&q.c0[BYTE_W-1:0]);
        hi_ovf   = hi_inc & (&q.c0[CNT_W-1:BYTE_W]);
    end

    for (genvar i = 0; i < NTMR; i++) begin : g_step
        dtmr_step u_step (
            .mode (md[i]),
            .inc  (inc[i]),
            .cnt_i(cin[i]),
            .cnt_o(cout[i]),
            .ovf  (ovf[i])
        );
    end

    always_comb begin
        logic set0, set1;
        d = q;
        if (t0_split) begin
            d.c0[BYTE_W-1:0]     = q.c0[BYTE_W-1:0] + BYTE_W'(lo_inc);
            d.c0[CNT_W-1:BYTE_W] = q.c0[CNT_W-1:BYTE_W] + BYTE_W'(hi_inc);
            set0 = lo_ovf;
            set1 = hi_ovf;
        end else begin
            d.c0 = cout[0];
            set0 = ovf[0];
            set1 = ovf[1];
        end
        d.c1   = cout[1];
        d.tick = ovf[1];
        if (wr_sel[0]) d.c0[BYTE_W-1:0]     = wr_data;
        if (wr_sel[1]) d.c0[CNT_W-1:BYTE_W] = wr_data;
        if (wr_sel[2]) d.c1[BYTE_W-1:0]     = wr_data;
        if (wr_sel[3]) d.c1[CNT_W-1:BYTE_W] = wr_data;
        if (ctl_we) d.ctl = ctl_t'(ctl_wdata);
        d.f0 = set0 | (q.f0 & ~clr0);
        d.f1 = set1 | (q.f1 & ~clr1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag0   = q.f0;
    assign flag1   = q.f1;
    assign t1_tick = q.tick;
    assign cnt0    = q.c0;
    assign cnt1    = q.c1;
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk
    import dtmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mc_en,
    input logic              gate_pin,
    input logic [3:0]        wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              clr0,
    input logic              flag0,
    input logic              flag1,
    input logic              t1_tick,
    input logic [CNT_W-1:0]  cnt0,
    input logic [CNT_W-1:0]  cnt1,
    input ctl_t              ctl
);
    p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_en && wr_sel == 4'b0) |=> cnt1 == $past(cnt1));

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode0 == 2'd3 && ctl.gate0 && !gate_pin && !wr_sel[0])
        |=> cnt0[BYTE_W-1:0] == $past(cnt0[BYTE_W-1:0]));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode1 == 2'd3 && wr_sel[3:2] == 2'b0) |=> cnt1 == $past(cnt1));

    p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        t1_tick |-> $past(ctl.mode1) != 2'd3);

    p_split_flag1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.mode0 == 2'd3 && !(ctl.run1 && mc_en)) |=> !$rose(flag1));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag0) |-> $past(clr0));

    p_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[0] |=> cnt0[BYTE_W-1:0] == $past(wr_data));
endmodule

bind dual_timer dtmr_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mc_en   (mc_en),
    .gate_pin(gate_pin),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .clr0    (clr0),
    .flag0   (flag0),
    .flag1   (flag1),
    .t1_tick (t1_tick),
    .cnt0    (cnt0),
    .cnt1    (cnt1),
    .ctl     (ctl_w)
);

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_en = 1'b1;
    logic        cnt_pin = 1'b1;
    logic        gate_pin = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [3:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        clr0 = 1'b0;
    logic        clr1 = 1'b0;
    logic        flag0, flag1, t1_tick;
    logic [15:0] cnt0, cnt1;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_timer dut (
        .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .wr_sel(wr_sel), .wr_data(wr_data), .clr0(clr0), .clr1(clr1),
        .flag0(flag0), .flag1(flag1), .t1_tick(t1_tick),
        .cnt0(cnt0), .cnt1(cnt1)
    );

    function automatic logic [7:0] mk(input logic [1:0] m1, input logic [1:0] m0,
                                      input logic src, input logic gt,
                                      input logic r1, input logic r0);
        return {m1, m0, src, gt, r1, r0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step(1);
        ctl_we = 1'b0;
    endtask

    task automatic wr_byte(input int sel, input logic [7:0] v);
        wr_sel = 4'b0001 << sel; wr_data = v;
        step(1);
        wr_sel = 4'b0;
    endtask

    task automatic quiesce();
        wr_ctl(8'h00);
        clr0 = 1'b1; clr1 = 1'b1;
        step(1);
        clr0 = 1'b0; clr1 = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cnt0", cnt0, 16'h0);
        chk("R1 cnt1", cnt1, 16'h0);
        chk("R1 flags/tick", {flag0, flag1, t1_tick}, 3'b000);
    endtask

    task automatic t_mode16();
        quiesce();
        wr_byte(0, 8'h00); wr_byte(1, 8'h00);
        wr_ctl(mk(2'd0, 2'd1, 0, 0, 0, 1));
        step(5);
        chk("R2 count 5", cnt0, 16'd5);
        for (int i = 0; i < 3; i++) begin
            mc_en = 1'b0; step(1);
            mc_en = 1'b1; step(1);
        end
        chk("R2 mc_en stall", cnt0, 16'd8);
        wr_ctl(mk(2'd0, 2'd1, 0, 0, 0, 0));
        step(3);
        chk("R2 run clear holds", cnt0, 16'd9);
        wr_byte(0, 8'hFF); wr_byte(1, 8'hFF);
        wr_ctl(mk(2'd0, 2'd1, 0, 0, 0, 1));
        chk("R2 no flag yet", flag0, 1'b0);
        step(1);
        chk("R2 wrap", cnt0, 16'h0000);
        chk("R2 flag0 set", flag0, 1'b1);
    endtask

    task automatic t_mode13();
        quiesce();
        wr_byte(0, 8'hFE); wr_byte(1, 8'hFF);
        wr_ctl(mk(2'd0, 2'd0, 0, 0, 0, 1));
        step(1);
        chk("R3 prescale top", cnt0, 16'hFFFF);
        chk("R3 no flag", flag0, 1'b0);
        step(1);
        chk("R3 wrap keeps upper bits", cnt0, 16'h00E0);
        chk("R3 flag0", flag0, 1'b1);
    endtask

    task automatic t_reload();
        quiesce();
        wr_byte(0, 8'hFE); wr_byte(1, 8'h80);
        wr_ctl(mk(2'd0, 2'd2, 0, 0, 0, 1));
        step(1);
        chk("R4 before reload", cnt0, 16'h80FF);
        step(1);
        chk("R4 reloaded", cnt0, 16'h8080);
        chk("R4 flag0", flag0, 1'b1);
        step(1);
        chk("R4 counts on", cnt0, 16'h8081);
    endtask

    task automatic t_split_low();
        quiesce();
        wr_byte(0, 8'hFD); wr_byte(1, 8'h10);
        gate_pin = 1'b0;
        wr_ctl(mk(2'd0, 2'd3, 0, 1, 0, 1));
        step(4);
        chk("R5 gated closed", cnt0, 16'h10FD);
        gate_pin = 1'b1;
        step(3);
        chk("R5 low wraps alone", cnt0, 16'h1000);
        chk("R5 flags", {flag0, flag1}, 2'b10);
        gate_pin = 1'b0;
    endtask

    task automatic t_split_high();
        quiesce();
        wr_byte(0, 8'h33); wr_byte(1, 8'hFE);
        wr_ctl(mk(2'd0, 2'd3, 0, 0, 1, 0));
        step(2);
        chk("R6 high wraps", cnt0, 16'h0033);
        chk("R6 flags", {flag0, flag1}, 2'b01);
    endtask

    task automatic t_t1_hold();
        quiesce();
        wr_byte(2, 8'h34); wr_byte(3, 8'h12);
        wr_ctl(mk(2'd3, 2'd1, 0, 0, 1, 0));
        step(5);
        chk("R7 held count", cnt1, 16'h1234);
        chk("R7 no tick", t1_tick, 1'b0);
    endtask

    task automatic t_t1_baud();
        quiesce();
        wr_byte(2, 8'hFE); wr_byte(3, 8'hFF);
        wr_ctl(mk(2'd1, 2'd3, 0, 0, 0, 0));
        step(1);
        chk("R8 runs with run1 clear", cnt1, 16'hFFFF);
        step(1);
        chk("R8 wrap", cnt1, 16'h0000);
        chk("R8 tick", t1_tick, 1'b1);
        chk("R8 flag1 untouched", flag1, 1'b0);
        step(1);
        chk("R8 tick one clock", {t1_tick, cnt1}, {1'b0, 16'h0001});
        wr_ctl(mk(2'd3, 2'd3, 0, 0, 0, 0));
        step(4);
        chk("R8 stopped by mode 3", cnt1, 16'h0002);
        wr_ctl(mk(2'd1, 2'd3, 0, 0, 0, 0));
        step(2);
        chk("R8 restarted", cnt1, 16'h0004);
    endtask

    task automatic t_t1_normal();
        quiesce();
        wr_byte(2, 8'hFF); wr_byte(3, 8'hFF);
        wr_ctl(mk(2'd1, 2'd1, 0, 0, 1, 0));
        step(1);
        chk("R12 wrap", cnt1, 16'h0000);
        chk("R12 tick and flag1", {t1_tick, flag1}, 2'b11);
        step(1);
        chk("R12 tick drops", t1_tick, 1'b0);
    endtask

    task automatic t_pin();
        quiesce();
        wr_byte(0, 8'h00); wr_byte(1, 8'h00);
        cnt_pin = 1'b1;
        wr_ctl(mk(2'd0, 2'd3, 1, 0, 0, 1));
        for (int i = 0; i < 3; i++) begin
            cnt_pin = 1'b0; step(3);
            cnt_pin = 1'b1; step(3);
        end
        step(2);
        chk("R9 one count per fall", cnt0, 16'h0003);
    endtask

    task automatic t_flags();
        quiesce();
        wr_byte(0, 8'hFF); wr_byte(1, 8'hFF);
        wr_ctl(mk(2'd0, 2'd1, 0, 0, 0, 1));
        clr0 = 1'b1;
        step(1);
        clr0 = 1'b0;
        chk("R10 set wins over clear", flag0, 1'b1);
        wr_ctl(8'h00);
        clr0 = 1'b1;
        step(1);
        clr0 = 1'b0;
        chk("R10 clear", flag0, 1'b0);
    endtask

    task automatic t_write();
        quiesce();
        wr_byte(0, 8'h00); wr_byte(1, 8'h00);
        wr_ctl(mk(2'd0, 2'd1, 0, 0, 0, 1));
        step(3);
        chk("R11 counting", cnt0, 16'h0003);
        wr_byte(0, 8'h55);
        chk("R11 write wins", cnt0, 16'h0055);
        step(1);
        chk("R11 counts from written", cnt0, 16'h0056);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode16();
        t_mode13();
        t_reload();
        t_split_low();
        t_split_high();
        t_t1_hold();
        t_t1_baud();
        t_t1_normal();
        t_pin();
        t_flags();
        t_write();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule